// File: doc/BRIEF.md
# Paired-Field GPIO Port with Level/Edge Interrupts

This block is one GPIO port of up to 32 pins behind a simple 32-bit register bus. Every pin carries two 2-bit settings: a function selector and an interrupt trigger selector. Each setting is spread over a pair of registers. Pins in the lower half of the port keep their fields in the "lo" register of the pair. Pins in the upper half keep theirs in the "hi" register. A function value of zero makes a pin a plain GPIO, and a direction bit then chooses whether the port drives the pad. Any non-zero function value hands the pad to the alternate peripheral with that number.

The pad inputs pass through a synchronizer. A per-pin detector then watches for a low level, a high level, a falling edge or a rising edge, according to the pin's trigger field. A match on an eligible pin sets a sticky flag. A pin is eligible when it is a GPIO and its enable bit is set. Software clears flags by writing ones to the flag register. The single interrupt output is the OR of the flags whose pins are enabled, unmasked and in GPIO mode. When the mask register is written so that a pin goes from masked to unmasked, the write also discards that pin's flag. This keeps an event left over from the masked period from firing.

Top module: `gpfield_gpio`

## Requirements
- R1: After reset every register reads zero, pad_oe, pad_out and alt_active are all zero and irq is low, so every pin starts as a GPIO input.
- R2: The bus map is: 0x00 synchronized pin level, read-only (writes are ignored); 0x04 output data; 0x08 direction; 0x10/0x14 function lo/hi; 0x18/0x1C trigger lo/hi; 0x20 interrupt enable; 0x24 mask; 0x28 flags. Each read/write register returns the last value written, and writing one register does not alter another.
- R3: Pin p's 2-bit field sits at bits [2*(p mod 16)+1 : 2*(p mod 16)], in the lo register for p < 16 and in the hi register for p >= 16.
- R4: If a pin's function field is 0 and its direction bit is 1, then pad_oe for that pin is 1 and pad_out follows the data register. If the function field is non-zero, then pad_oe is 0 and alt_active is 1 for that pin.
- R5: Trigger code 0 flags a low level, 1 a high level, 2 a falling edge and 3 a rising edge. The opposite level or edge sets no flag. With two synchronizer stages, a pad change made between clock edges shows in the flag register after the third rising edge, and not after the second.
- R6: A pin can set its flag only when its function field is zero and its enable bit is 1.
- R7: Writing the flag register clears each flag bit written as 1. Bits written as 0 are unchanged.
- R8: If a pin's trigger condition is present in the same cycle that its flag is cleared, the flag stays set.
- R9: irq is high exactly when some pin has its flag set, its enable bit set, its mask bit clear (mask bit 1 means masked) and its function field zero.
- R10: A mask write that takes a pin's mask bit from 1 to 0 clears that pin's flag in the same cycle. A mask write that leaves a bit at 0 leaves the flag alone.
- R11: A flag stays set after its trigger condition goes away, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (8) | Register byte address |
| bus_wdata | input | NPINS (32) | Write data |
| bus_rdata | output | NPINS (32) | Read data for bus_addr (combinational) |
| pad_in | input | NPINS (32) | Asynchronous pad input levels |
| pad_out | output | NPINS (32) | GPIO output values |
| pad_oe | output | NPINS (32) | GPIO output enables |
| alt_active | output | NPINS (32) | Pin is given to its alternate function |
| irq | output | 1 | Combined interrupt request |

## Verification
The flag logic can see a detector hit in the same cycle as a clearing event. The clearing event is either a write-one-to-clear or a mask write that unmasks the pin. The bench provokes the first case by holding a level trigger true while it writes ones to the flag register; the flag must survive. In the second case the trigger is removed first, so the unmask write alone must clear the flag. A sweep over all 32 pins and all four trigger codes checks the exact latency of the set, the rejection of the opposite polarity, and the difference between sticky level flags and edge flags after a clear.

// File: rtl/gpfield_pkg.sv
package gpfield_pkg;
   localparam logic [7:0] OFF_LEVEL  = 8'h00;
   localparam logic [7:0] OFF_DOUT   = 8'h04;
   localparam logic [7:0] OFF_DIR    = 8'h08;
   localparam logic [7:0] OFF_FN_LO  = 8'h10;
   localparam logic [7:0] OFF_FN_HI  = 8'h14;
   localparam logic [7:0] OFF_DET_LO = 8'h18;
   localparam logic [7:0] OFF_DET_HI = 8'h1C;
   localparam logic [7:0] OFF_IEN    = 8'h20;
   localparam logic [7:0] OFF_MASK   = 8'h24;
   localparam logic [7:0] OFF_FLAG   = 8'h28;

   typedef enum logic [1:0] {
      TRIG_LOW  = 2'd0,
      TRIG_HIGH = 2'd1,
      TRIG_FALL = 2'd2,
      TRIG_RISE = 2'd3
   } trig_e;
endpackage

// File: rtl/gpfield_sync.sv
module gpfield_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= din;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpfield_detect.sv
module gpfield_detect
   import gpfield_pkg::*;
#(
   parameter int NPINS = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NPINS-1:0]      lvl,
   input  logic [NPINS-1:0][1:0] trig,
   input  logic [NPINS-1:0]      src_ok,
   output logic [NPINS-1:0]      hit
);
   logic [NPINS-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      logic cond;
      always_comb begin
         unique case (trig_e'(trig[p]))
            TRIG_LOW:  cond = !lvl[p];
            TRIG_HIGH: cond =  lvl[p];
            TRIG_FALL: cond =  prev_q[p] && !lvl[p];
            TRIG_RISE: cond = !prev_q[p] &&  lvl[p];
            default:   cond = 1'b0;
         endcase
      end
      assign hit[p] = cond && src_ok[p];

      // R5: an edge hit needs a level change since the previous cycle
      p_edge_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (hit[p] && trig[p][1]) |-> (lvl[p] != $past(lvl[p])));
   end
endmodule

// File: rtl/gpfield_regs.sv
module gpfield_regs
   import gpfield_pkg::*;
#(
   parameter int NPINS  = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [NPINS-1:0]  bus_wdata,
   output logic [NPINS-1:0]  bus_rdata,
   input  logic [NPINS-1:0]  lvl,
   input  logic [NPINS-1:0]  hit,
   output logic [NPINS-1:0]  dout_q,
   output logic [NPINS-1:0]  dir_q,
   output logic [NPINS-1:0]  fn_lo_q,
   output logic [NPINS-1:0]  fn_hi_q,
   output logic [NPINS-1:0]  det_lo_q,
   output logic [NPINS-1:0]  det_hi_q,
   output logic [NPINS-1:0]  ien_q,
   output logic [NPINS-1:0]  mask_q,
   output logic [NPINS-1:0]  flag_q
);
   localparam logic [ADDR_W-1:0] A_LEVEL  = ADDR_W'(OFF_LEVEL);
   localparam logic [ADDR_W-1:0] A_DOUT   = ADDR_W'(OFF_DOUT);
   localparam logic [ADDR_W-1:0] A_DIR    = ADDR_W'(OFF_DIR);
   localparam logic [ADDR_W-1:0] A_FN_LO  = ADDR_W'(OFF_FN_LO);
   localparam logic [ADDR_W-1:0] A_FN_HI  = ADDR_W'(OFF_FN_HI);
   localparam logic [ADDR_W-1:0] A_DET_LO = ADDR_W'(OFF_DET_LO);
   localparam logic [ADDR_W-1:0] A_DET_HI = ADDR_W'(OFF_DET_HI);
   localparam logic [ADDR_W-1:0] A_IEN    = ADDR_W'(OFF_IEN);
   localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFF_MASK);
   localparam logic [ADDR_W-1:0] A_FLAG   = ADDR_W'(OFF_FLAG);

   logic             wr_flag, wr_mask;
   logic [NPINS-1:0] w1c, unmask_clr, flag_nxt;

   assign wr_flag = bus_wr && (bus_addr == A_FLAG);
   assign wr_mask = bus_wr && (bus_addr == A_MASK);

   always_comb begin
      w1c        = wr_flag ? bus_wdata : '0;
      unmask_clr = wr_mask ? (mask_q & ~bus_wdata) : '0;
      flag_nxt   = (flag_q & ~w1c & ~unmask_clr) | hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q   <= '0;
         dir_q    <= '0;
         fn_lo_q  <= '0;
         fn_hi_q  <= '0;
         det_lo_q <= '0;
         det_hi_q <= '0;
         ien_q    <= '0;
         mask_q   <= '0;
         flag_q   <= '0;
      end else begin
         if (bus_wr) begin
            if (bus_addr == A_DOUT)   dout_q   <= bus_wdata;
            if (bus_addr == A_DIR)    dir_q    <= bus_wdata;
            if (bus_addr == A_FN_LO)  fn_lo_q  <= bus_wdata;
            if (bus_addr == A_FN_HI)  fn_hi_q  <= bus_wdata;
            if (bus_addr == A_DET_LO) det_lo_q <= bus_wdata;
            if (bus_addr == A_DET_HI) det_hi_q <= bus_wdata;
            if (bus_addr == A_IEN)    ien_q    <= bus_wdata;
            if (bus_addr == A_MASK)   mask_q   <= bus_wdata;
         end
         flag_q <= flag_nxt;
      end
   end

   always_comb begin
      unique case (bus_addr)
         A_LEVEL:  bus_rdata = lvl;
         A_DOUT:   bus_rdata = dout_q;
         A_DIR:    bus_rdata = dir_q;
         A_FN_LO:  bus_rdata = fn_lo_q;
         A_FN_HI:  bus_rdata = fn_hi_q;
         A_DET_LO: bus_rdata = det_lo_q;
         A_DET_HI: bus_rdata = det_hi_q;
         A_IEN:    bus_rdata = ien_q;
         A_MASK:   bus_rdata = mask_q;
         A_FLAG:   bus_rdata = flag_q;
         default:  bus_rdata = '0;
      endcase
   end

   // R6: a newly set flag always comes from a detector hit
   p_flag_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q & ~$past(flag_q) & ~$past(hit)) == '0);
   // R7: written ones clear unless a hit arrived together with the write
   p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_flag) |-> ((flag_q & $past(bus_wdata) & ~$past(hit)) == '0));
   // R8: a hit always leaves its flag set
   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |=> ((flag_q & $past(hit)) == $past(hit)));
   // R10: unmasking a pin drops its flag
   p_unmask_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_mask) |->
         ((flag_q & $past(mask_q) & ~$past(bus_wdata) & ~$past(hit)) == '0));
   // R11: without a bus write no flag is lost
   p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_wr) |-> (($past(flag_q) & ~flag_q) == '0));
endmodule

// File: rtl/gpfield_gpio.sv
module gpfield_gpio
   import gpfield_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [NPINS-1:0]  bus_wdata,
   output logic [NPINS-1:0]  bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   output logic [NPINS-1:0]  alt_active,
   output logic              irq
);
   localparam int HALF = NPINS / 2;

   if (NPINS % 2 != 0 || NPINS < 2 || NPINS > 32) begin : g_bad_npins
      $error("gpfield_gpio: NPINS must be even and within 2..32");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("gpfield_gpio: ADDR_W too small for the register map");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpfield_gpio: SYNC_STAGES must be at least 2");
   end

   logic [NPINS-1:0] lvl, hit, src_ok, gpio_mode;
   logic [NPINS-1:0] dout_q, dir_q, fn_lo_q, fn_hi_q, det_lo_q, det_hi_q;
   logic [NPINS-1:0] ien_q, mask_q, flag_q;
   logic [NPINS-1:0][1:0] fn_c, trig_c;

   gpfield_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(lvl));

   gpfield_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lvl(lvl), .hit(hit),
      .dout_q(dout_q), .dir_q(dir_q), .fn_lo_q(fn_lo_q), .fn_hi_q(fn_hi_q),
      .det_lo_q(det_lo_q), .det_hi_q(det_hi_q), .ien_q(ien_q),
      .mask_q(mask_q), .flag_q(flag_q));

   for (genvar p = 0; p < NPINS; p++) begin : g_field
      localparam int SH = 2 * (p % HALF);
      if (p < HALF) begin : g_lo
         assign fn_c[p]   = fn_lo_q[SH +: 2];
         assign trig_c[p] = det_lo_q[SH +: 2];
      end else begin : g_hi
         assign fn_c[p]   = fn_hi_q[SH +: 2];
         assign trig_c[p] = det_hi_q[SH +: 2];
      end
      assign gpio_mode[p]  = (fn_c[p] == 2'd0);
      assign alt_active[p] = !gpio_mode[p];
      assign pad_oe[p]     = gpio_mode[p] && dir_q[p];
      assign src_ok[p]     = gpio_mode[p] && ien_q[p];
   end

   gpfield_detect #(.NPINS(NPINS)) u_detect (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .trig(trig_c),
      .src_ok(src_ok), .hit(hit));

   assign pad_out = dout_q;
   assign irq     = |(flag_q & ien_q & ~mask_q & gpio_mode);

   // R6: the detector never fires for an ineligible pin
   p_hit_eligible_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit & ~src_ok) == '0);
   // R9: no enabled, unmasked flag means no interrupt
   p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_q & ien_q & ~mask_q) == '0) |-> !irq);
   // R4: the port never drives a pad that an alternate function owns
   p_oe_gpio_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & alt_active) == '0);
endmodule

// File: tb/gpfield_gpio_tb_top.sv
`timescale 1ns/1ps
module gpfield_gpio_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = '0;
   logic [31:0] pad_in = '0;
   logic [31:0] bus_rdata, pad_out, pad_oe, alt_active;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   gpfield_gpio dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .alt_active(alt_active), .irq(irq));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [7:0]  offs [8];
      offs = '{8'h04, 8'h08, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24};

      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1: reset state
      for (int i = 0; i < 8; i++) begin
         rd(offs[i], v); chk("R1 reg reset", v, 32'h0);
      end
      rd(8'h28, v); chk("R1 flag reset", v, 32'h0);
      chk("R1 pad_oe", pad_oe, 32'h0);
      chk("R1 pad_out", pad_out, 32'h0);
      chk("R1 alt_active", alt_active, 32'h0);
      chk("R1 irq", {31'h0, irq}, 32'h0);

      // R2: read/write map, independent registers
      for (int i = 0; i < 8; i++) wr(offs[i], 32'h9E3779B9 * (i + 1));
      for (int i = 0; i < 8; i++) begin
         rd(offs[i], v); chk("R2 readback", v, 32'h9E3779B9 * (i + 1));
      end
      for (int i = 0; i < 8; i++) wr(offs[i], 32'h0);
      wr(8'h28, 32'hFFFFFFFF);
      pad_in = 32'h12345678;
      idle(3);
      rd(8'h00, v); chk("R2 pin level", v, 32'h12345678);
      wr(8'h00, 32'hFFFFFFFF);
      rd(8'h00, v); chk("R2 level read-only", v, 32'h12345678);
      pad_in = 32'h0;
      idle(3);

      // R3/R4: pin 5 alt 2 (lo, bits 11:10), pin 20 alt 1 (hi, bits 9:8)
      wr(8'h10, 32'h2 << 10);
      wr(8'h14, 32'h1 << 8);
      wr(8'h08, 32'hFFFFFFFF);
      wr(8'h04, 32'hAAAAAAAA);
      chk("R3 alt_active field position", alt_active, (32'h1 << 5) | (32'h1 << 20));
      chk("R4 pad_oe", pad_oe, ~((32'h1 << 5) | (32'h1 << 20)));
      chk("R4 pad_out", pad_out, 32'hAAAAAAAA);
      wr(8'h08, 32'h0);
      chk("R4 pad_oe dir=0", pad_oe, 32'h0);

      // R6: enabled alt pins with low-level trigger and low pad: no flag
      wr(8'h20, (32'h1 << 5) | (32'h1 << 20));
      idle(5);
      rd(8'h28, v); chk("R6 alt pin no flag", v, 32'h0);
      chk("R6 irq", {31'h0, irq}, 32'h0);
      wr(8'h10, 32'h0);
      wr(8'h14, 32'h0);
      idle(2);
      rd(8'h28, v); chk("R6 gpio pin flags", v, (32'h1 << 5) | (32'h1 << 20));
      chk("R9 irq raised", {31'h0, irq}, 32'h1);

      // R8: clear while level still present
      wr(8'h28, 32'hFFFFFFFF);
      rd(8'h28, v); chk("R8 set wins over clear", v, (32'h1 << 5) | (32'h1 << 20));

      // R9: masking hides irq
      wr(8'h24, (32'h1 << 5) | (32'h1 << 20));
      chk("R9 masked irq", {31'h0, irq}, 32'h0);

      // R11: remove condition (code 1 = high level, pad low)
      wr(8'h18, 32'h1 << 10);
      wr(8'h1C, 32'h1 << 8);
      idle(3);
      rd(8'h28, v); chk("R11 sticky", v, (32'h1 << 5) | (32'h1 << 20));

      // R10: unmask pin 5 only
      wr(8'h24, 32'h1 << 20);
      rd(8'h28, v); chk("R10 unmask clears", v, 32'h1 << 20);
      chk("R10 irq after unmask", {31'h0, irq}, 32'h0);
      wr(8'h24, 32'h1 << 20);
      rd(8'h28, v); chk("R10 no unmask keeps", v, 32'h1 << 20);

      // R7: zeros do nothing, ones clear
      wr(8'h28, 32'h0);
      rd(8'h28, v); chk("R7 write zero", v, 32'h1 << 20);
      wr(8'h28, 32'h1 << 20);
      rd(8'h28, v); chk("R7 write one", v, 32'h0);

      wr(8'h24, 32'h0); wr(8'h20, 32'h0);
      wr(8'h18, 32'h0); wr(8'h1C, 32'h0);
      wr(8'h04, 32'h0);

      // R5/R3 sweep: every pin, every trigger code
      for (int p = 0; p < 32; p++) begin
         for (int c = 0; c < 4; c++) begin
            logic       inact;
            logic [7:0] da;
            logic [31:0] bit_p;
            inact = (c == 0 || c == 2);
            da    = (p < 16) ? 8'h18 : 8'h1C;
            bit_p = 32'h1 << p;
            pad_in[p] = inact;
            wr(da, 32'(c) << (2 * (p % 16)));
            wr(8'h20, bit_p);
            idle(4);
            wr(8'h28, 32'hFFFFFFFF);
            rd(8'h28, v); chk("R5 inactive no flag", v, 32'h0);
            pad_in[p] = ~inact;
            idle(2);
            rd(8'h28, v); chk("R5 not before third edge", v, 32'h0);
            idle(1);
            rd(8'h28, v); chk("R5 flag on trigger", v, bit_p);
            chk("R9 irq on flag", {31'h0, irq}, 32'h1);
            idle(1);
            wr(8'h28, 32'hFFFFFFFF);
            rd(8'h28, v);
            chk("R8 level persists / edge clears", v, (c < 2) ? bit_p : 32'h0);
            pad_in[p] = inact;
            idle(4);
            rd(8'h28, v);
            chk("R11 level sticky / R5 opposite edge ignored", v, (c < 2) ? bit_p : 32'h0);
            wr(8'h28, 32'hFFFFFFFF);
            rd(8'h28, v); chk("R7 cleared", v, 32'h0);
            wr(8'h20, 32'h0);
            wr(da, 32'h0);
         end
         pad_in[p] = 1'b0;
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule